// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Interlock

This block is the interlock controller for an in-order pipeline with four stages (fetch, decode with operand read, execute, write result), each separated by a buffer register. Every clock it compares the source register numbers of the instruction sitting in decode with the destination of the instruction in execute. It then chooses between two remedies. One is a bypass that routes the previous ALU result back to the ALU input. The other is a stall that holds decode and sends an empty slot into execute. The register file is assumed to write in the first half of a cycle and read in the second half, so an instruction in the write stage never conflicts with decode.

The controller also handles two other events. An execute operation that needs several cycles, such as a divide, freezes everything behind it. A fetch that misses the instruction cache makes fetch repeat the same address while empty slots flow down the pipe. The block drives only hold enables, bubble commands and per-operand bypass selects. The pipeline buffers, register file, ALU and caches lie outside it. A bubble is a buffer load with the valid bit cleared and the write enable suppressed; the buffers carry this out when commanded. The parameter `FWD_EN` selects whether the bypass path exists.

Top module: `hz_interlock`

## Requirements
- R1: During reset and after reset release with idle inputs (no valid instruction, `fetch_ready`=1, `ex_busy`=0), all six control outputs are 0 and `fwd_sel` is all zeros.
- R2: With `FWD_EN`=0, when a valid decode instruction has a non-zero source number equal to `ex_dst` of a valid, writing execute instruction, `hold_pc`, `hold_fd` and `bub_de` are 1 in that same cycle, and `hold_de`, `bub_fd` and `bub_ew` are 0.
- R3: Register number 0 never forms a dependency. A source never matches when `dec_valid`, `ex_valid` or `ex_wen` is 0. In those cases no hold or bubble is raised, and `fwd_sel` loads 0 at the next edge.
- R4: With `FWD_EN`=1, a dependency never raises a hold or bubble. At the clock edge where the consumer leaves decode, bit i of `fwd_sel` is set for each matching operand i. Operand i is `dec_src[i*REG_W +: REG_W]`, and a 1 bit means the bypass is chosen over the register-file value.
- R5: `fwd_sel` describes the instruction that entered execute. It is cleared when an invalid instruction or a bubble enters execute. Operands that do not match read 0.
- R6: When `ex_valid` and `ex_busy` are both 1, `hold_pc`, `hold_fd`, `hold_de` and `bub_ew` are 1, and `bub_fd` and `bub_de` are 0. `fwd_sel` keeps its value across such cycles. `ex_busy` with `ex_valid`=0 has no effect.
- R7: When `fetch_ready` is 0, `hold_pc` is 1. `bub_fd` is also 1 unless decode is being held. A fetch miss alone raises none of `hold_de`, `bub_de` or `bub_ew`.
- R8: The causes are ranked: a multi-cycle execute outranks a data dependency, and a held decode outranks a fetch bubble. `hold_fd` and `bub_fd` are never 1 together, and neither are `hold_de` and `bub_de`.
- R9: With `FWD_EN`=0, `fwd_sel` stays all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_src | input | NUM_SRC*REG_W | Source register numbers of the decode instruction, operand i at bits i*REG_W |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_dst | input | REG_W | Destination register number of the execute instruction |
| ex_busy | input | 1 | Execute operation needs further cycles |
| fetch_ready | input | 1 | Instruction fetch completes this cycle |
| hold_pc | output | 1 | Fetch repeats the same instruction address |
| hold_fd | output | 1 | Fetch/decode buffer keeps its contents |
| hold_de | output | 1 | Decode/execute buffer keeps its contents |
| bub_fd | output | 1 | Fetch/decode buffer loads a bubble |
| bub_de | output | 1 | Decode/execute buffer loads a bubble |
| bub_ew | output | 1 | Execute/write buffer loads a bubble |
| fwd_sel | output | NUM_SRC | Per-operand ALU input select, 1 = bypass |

## Verification
On every cycle, the assertions check the ranking of the three stall causes, the hold and bubble pairs that must never occur together, and the freeze of `fwd_sel` while execute is held. They also check that a bubble or an empty slot entering execute clears the select, and that the no-bypass variant never raises a select. Only the bench scenarios can show that a specific register match produces the correct stall in one variant and the correct operand select one edge later in the other. The same holds for register 0, missing write enables and invalid slots, which must never match.

// File: rtl/hz_pkg.sv
// Shared types and helpers for the hazard interlock.
// Assumes register numbers are unsigned and that number 0 is hard-wired.
package hz_pkg;

    // Control commands issued to the pipeline buffers each cycle.
    typedef struct packed {
        logic hold_pc;
        logic hold_fd;
        logic hold_de;
        logic bub_fd;
        logic bub_de;
        logic bub_ew;
    } hz_ctrl_t;

    // A register number can carry a dependency only if it is non-zero.
    function automatic logic reg_live(input logic [7:0] num);
        return num != 8'd0;
    endfunction

endpackage

// File: rtl/hz_src_match.sv
// Compares every decode source number against the execute destination.
// Assumes REG_W <= 8. Produces one match bit per source operand; a match
// needs both instructions valid, a write in execute, and a non-zero number.
module hz_src_match #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                       dec_valid,
    input  logic [NUM_SRC*REG_W-1:0]   dec_src,
    input  logic                       ex_valid,
    input  logic                       ex_wen,
    input  logic [REG_W-1:0]           ex_dst,
    output logic [NUM_SRC-1:0]         match
);
    import hz_pkg::*;

    localparam int PADW = 8 - REG_W;

    logic producer_ok;

    // Purpose: a producer counts only if it is real and writes a register.
    assign producer_ok = dec_valid && ex_valid && ex_wen;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
        logic [REG_W-1:0] src_i;
        assign src_i = dec_src[i*REG_W +: REG_W];
        // Purpose: per-operand equality check, ignoring register 0.
        always_comb begin
            match[i] = producer_ok
                       && (src_i == ex_dst)
                       && reg_live({{PADW{1'b0}}, src_i});
        end
    end

endmodule

// File: rtl/hz_stall_ctrl.sv
// Ranks the stall causes and turns them into hold and bubble commands.
// Assumes the register file writes before it reads within a cycle, so
// only the execute-stage producer can conflict with decode.
// USE_FWD = 1 removes data-dependency stalls (the bypass covers them).
module hz_stall_ctrl #(
    parameter bit USE_FWD = 1'b1
) (
    input  logic          dep_any,
    input  logic          ex_valid,
    input  logic          ex_busy,
    input  logic          fetch_ready,
    output hz_pkg::hz_ctrl_t ctrl
);
    import hz_pkg::*;

    logic mc_stall;
    logic data_stall;

    // Purpose: a multi-cycle op only blocks when execute is occupied.
    assign mc_stall = ex_valid && ex_busy;

    if (USE_FWD) begin : g_fwd
        // Purpose: bypass variant never stalls on a dependency.
        assign data_stall = 1'b0 & dep_any;
    end else begin : g_nofwd
        // Purpose: no bypass, so decode waits one cycle for the producer.
        assign data_stall = dep_any && !mc_stall;
    end

    // Purpose: combine causes; multi-cycle first, then data, then fetch miss.
    always_comb begin
        ctrl          = '0;
        ctrl.hold_pc  = mc_stall || data_stall || !fetch_ready;
        ctrl.hold_fd  = mc_stall || data_stall;
        ctrl.hold_de  = mc_stall;
        ctrl.bub_ew   = mc_stall;
        ctrl.bub_de   = data_stall;
        ctrl.bub_fd   = !fetch_ready && !(mc_stall || data_stall);
    end

endmodule

// File: rtl/hz_fwd_sel.sv
// Holds the per-operand bypass select for the instruction in execute.
// Assumes the producer in execute moves to write in the same edge that the
// consumer moves from decode to execute, so the select is loaded then.
module hz_fwd_sel #(
    parameter int NUM_SRC = 2,
    parameter bit USE_FWD = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    input  logic [NUM_SRC-1:0] match,
    input  logic               hold_de,
    input  logic               bub_de,
    output logic [NUM_SRC-1:0] fwd_sel
);
    logic [NUM_SRC-1:0] next_sel;

    if (USE_FWD) begin : g_fwd
        // Purpose: a matched operand takes the bypass in the next cycle.
        assign next_sel = match;
    end else begin : g_nofwd
        // Purpose: no bypass wiring; operands always read the register file.
        assign next_sel = match & '0;
    end

    // Purpose: load on decode advance, freeze on hold, clear on empty slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_sel <= '0;
        end else if (hold_de) begin
            fwd_sel <= fwd_sel;
        end else if (bub_de || !dec_valid) begin
            fwd_sel <= '0;
        end else begin
            fwd_sel <= next_sel;
        end
    end

endmodule

// File: rtl/hz_interlock.sv
// Top of the four-stage pipeline hazard interlock.
// Assumes the buffers act on the commands in the same cycle and that a
// bubble clears valid and write enable. FWD_EN picks the bypass variant.
module hz_interlock #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter bit FWD_EN  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dec_valid,
    input  logic [NUM_SRC*REG_W-1:0] dec_src,
    input  logic                     ex_valid,
    input  logic                     ex_wen,
    input  logic [REG_W-1:0]         ex_dst,
    input  logic                     ex_busy,
    input  logic                     fetch_ready,
    output logic                     hold_pc,
    output logic                     hold_fd,
    output logic                     hold_de,
    output logic                     bub_fd,
    output logic                     bub_de,
    output logic                     bub_ew,
    output logic [NUM_SRC-1:0]       fwd_sel
);
    import hz_pkg::*;

    logic [NUM_SRC-1:0] match;
    hz_ctrl_t           ctrl;

    hz_src_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_match (
        .dec_valid (dec_valid),
        .dec_src   (dec_src),
        .ex_valid  (ex_valid),
        .ex_wen    (ex_wen),
        .ex_dst    (ex_dst),
        .match     (match)
    );

    hz_stall_ctrl #(.USE_FWD(FWD_EN)) u_ctrl (
        .dep_any     (|match),
        .ex_valid    (ex_valid),
        .ex_busy     (ex_busy),
        .fetch_ready (fetch_ready),
        .ctrl        (ctrl)
    );

    hz_fwd_sel #(.NUM_SRC(NUM_SRC), .USE_FWD(FWD_EN)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .match     (match),
        .hold_de   (ctrl.hold_de),
        .bub_de    (ctrl.bub_de),
        .fwd_sel   (fwd_sel)
    );

    // Purpose: present the command struct on individual ports.
    assign hold_pc = ctrl.hold_pc;
    assign hold_fd = ctrl.hold_fd;
    assign hold_de = ctrl.hold_de;
    assign bub_fd  = ctrl.bub_fd;
    assign bub_de  = ctrl.bub_de;
    assign bub_ew  = ctrl.bub_ew;

endmodule

// File: rtl/hz_interlock_chk.sv
// Assertion checker for hz_interlock, attached by bind.
// Assumes the same parameters as the bound instance.
module hz_interlock_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter bit FWD_EN  = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     dec_valid,
    input logic [NUM_SRC*REG_W-1:0] dec_src,
    input logic                     ex_valid,
    input logic                     ex_wen,
    input logic [REG_W-1:0]         ex_dst,
    input logic                     ex_busy,
    input logic                     fetch_ready,
    input logic                     hold_pc,
    input logic                     hold_fd,
    input logic                     hold_de,
    input logic                     bub_fd,
    input logic                     bub_de,
    input logic                     bub_ew,
    input logic [NUM_SRC-1:0]       fwd_sel
);
    // R6: multi-cycle execute freezes the front and empties write
    p_busy_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_busy) |-> (hold_pc && hold_fd && hold_de && bub_ew && !bub_fd && !bub_de));

    // R6: select frozen while execute is held
    p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_de |=> $stable(fwd_sel));

    // R5: bubble into execute clears the select
    p_sel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bub_de || (!dec_valid && !hold_de)) |=> (fwd_sel == '0));

    // R7: a fetch miss always repeats the fetch
    p_miss_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ready |-> hold_pc);

    // R8: conflicting commands never coincide
    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_fd && bub_fd) && !(hold_de && bub_de));

    // R3: invalid decode slot never causes a hold or bubble by itself
    p_idle_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !(ex_valid && ex_busy) && fetch_ready) |-> !(hold_pc || bub_de || bub_fd));

    if (FWD_EN) begin : g_fwd_chk
        // R4: with bypass, decode is only held by a multi-cycle op
        p_no_data_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(ex_valid && ex_busy) |-> (!hold_fd && !bub_de));
    end else begin : g_nofwd_chk
        // R9: no bypass variant never selects the bypass
        p_sel_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_sel == '0);
    end

endmodule

bind hz_interlock hz_interlock_chk #(
    .REG_W(REG_W), .NUM_SRC(NUM_SRC), .FWD_EN(FWD_EN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
    .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_busy(ex_busy),
    .fetch_ready(fetch_ready), .hold_pc(hold_pc), .hold_fd(hold_fd),
    .hold_de(hold_de), .bub_fd(bub_fd), .bub_de(bub_de), .bub_ew(bub_ew),
    .fwd_sel(fwd_sel)
);

// File: tb/hz_interlock_tb.sv
`timescale 1ns/1ps
// Directed bench: one bypass instance (u_dut) and one stall-only instance.
module hz_interlock_tb;
    localparam int RW = 5;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0;
    logic [NS*RW-1:0] dec_src = '0;
    logic ex_valid = 1'b0, ex_wen = 1'b0, ex_busy = 1'b0, fetch_ready = 1'b1;
    logic [RW-1:0] ex_dst = '0;

    logic f_hpc, f_hfd, f_hde, f_bfd, f_bde, f_bew;
    logic n_hpc, n_hfd, n_hde, n_bfd, n_bde, n_bew;
    logic [NS-1:0] f_sel, n_sel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hz_interlock #(.REG_W(RW), .NUM_SRC(NS), .FWD_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
        .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_busy(ex_busy),
        .fetch_ready(fetch_ready), .hold_pc(f_hpc), .hold_fd(f_hfd), .hold_de(f_hde),
        .bub_fd(f_bfd), .bub_de(f_bde), .bub_ew(f_bew), .fwd_sel(f_sel));

    hz_interlock #(.REG_W(RW), .NUM_SRC(NS), .FWD_EN(1'b0)) u_dut_nf (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
        .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_busy(ex_busy),
        .fetch_ready(fetch_ready), .hold_pc(n_hpc), .hold_fd(n_hfd), .hold_de(n_hde),
        .bub_fd(n_bfd), .bub_de(n_bde), .bub_ew(n_bew), .fwd_sel(n_sel));

    // control order: hold_pc hold_fd hold_de bub_fd bub_de bub_ew
    wire [5:0] f_ctl = {f_hpc, f_hfd, f_hde, f_bfd, f_bde, f_bew};
    wire [5:0] n_ctl = {n_hpc, n_hfd, n_hde, n_bfd, n_bde, n_bew};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at the falling edge, then let combinational outputs settle
    task automatic drive(input logic dv, input logic [RW-1:0] sa, input logic [RW-1:0] sb,
                         input logic ev, input logic ew, input logic [RW-1:0] ed,
                         input logic busy, input logic frdy);
        @(negedge clk);
        dec_valid = dv; dec_src = {sb, sa};
        ex_valid = ev; ex_wen = ew; ex_dst = ed;
        ex_busy = busy; fetch_ready = frdy;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        tick();
        check("R1 ctl in reset", {2'b0, f_ctl}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        tick();
        check("R1 fwd ctl idle", {2'b0, f_ctl}, 8'h00);
        check("R1 nofwd ctl idle", {2'b0, n_ctl}, 8'h00);
        check("R1 fwd_sel idle", {6'b0, f_sel}, 8'h00);
    endtask

    task automatic t_dependency();
        drive(1, 5'd4, 5'd3, 1, 1, 5'd4, 0, 1);
        check("R2 nofwd stall on operand a", {2'b0, n_ctl}, 8'b00110010);
        check("R4 fwd no stall", {2'b0, f_ctl}, 8'h00);
        tick();
        check("R4 fwd_sel operand a", {6'b0, f_sel}, 8'b01);
        check("R9 nofwd sel zero", {6'b0, n_sel}, 8'b00);
        drive(1, 5'd1, 5'd7, 1, 1, 5'd7, 0, 1);
        check("R2 nofwd stall on operand b", {2'b0, n_ctl}, 8'b00110010);
        tick();
        check("R4 R5 fwd_sel operand b only", {6'b0, f_sel}, 8'b10);
        drive(1, 5'd9, 5'd9, 1, 1, 5'd9, 0, 1);
        tick();
        check("R4 fwd_sel both operands", {6'b0, f_sel}, 8'b11);
        drive(1, 5'd2, 5'd6, 1, 1, 5'd9, 0, 1);
        check("R2 nofwd no match no stall", {2'b0, n_ctl}, 8'h00);
        tick();
        check("R5 fwd_sel no match", {6'b0, f_sel}, 8'b00);
    endtask

    task automatic t_no_dep();
        drive(1, 5'd0, 5'd3, 1, 1, 5'd0, 0, 1);
        check("R3 reg0 no stall", {2'b0, n_ctl}, 8'h00);
        tick();
        check("R3 reg0 no forward", {6'b0, f_sel}, 8'b00);
        drive(1, 5'd8, 5'd8, 1, 0, 5'd8, 0, 1);
        check("R3 no write enable no stall", {2'b0, n_ctl}, 8'h00);
        tick();
        check("R3 no write enable no forward", {6'b0, f_sel}, 8'b00);
        drive(1, 5'd8, 5'd8, 0, 1, 5'd8, 0, 1);
        check("R3 execute invalid no stall", {2'b0, n_ctl}, 8'h00);
        drive(1, 5'd4, 5'd4, 1, 1, 5'd4, 0, 1);
        tick();
        drive(0, 5'd4, 5'd4, 1, 1, 5'd4, 0, 1);
        check("R3 decode invalid no stall", {2'b0, n_ctl}, 8'h00);
        tick();
        check("R3 R5 decode invalid clears select", {6'b0, f_sel}, 8'b00);
    endtask

    task automatic t_multicycle();
        drive(1, 5'd4, 5'd3, 1, 1, 5'd4, 0, 1);
        tick();
        drive(1, 5'd2, 5'd2, 1, 1, 5'd6, 1, 1);
        check("R6 busy holds front fwd", {2'b0, f_ctl}, 8'b00111001);
        check("R6 busy holds front nofwd", {2'b0, n_ctl}, 8'b00111001);
        tick();
        check("R6 select kept while busy", {6'b0, f_sel}, 8'b01);
        drive(1, 5'd2, 5'd2, 0, 1, 5'd6, 1, 1);
        check("R6 busy without valid ignored", {2'b0, f_ctl}, 8'h00);
    endtask

    task automatic t_fetch_miss();
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 miss repeats fetch", {2'b0, f_ctl}, 8'b00100100);
        drive(1, 5'd5, 5'd1, 1, 1, 5'd5, 0, 0);
        check("R7 R8 miss with data stall nofwd", {2'b0, n_ctl}, 8'b00110010);
        check("R7 miss with dependency fwd", {2'b0, f_ctl}, 8'b00100100);
    endtask

    task automatic t_priority();
        drive(1, 5'd5, 5'd1, 1, 1, 5'd5, 1, 1);
        check("R8 busy outranks dependency", {2'b0, n_ctl}, 8'b00111001);
        drive(1, 5'd5, 5'd1, 1, 1, 5'd5, 1, 0);
        check("R8 busy outranks miss", {2'b0, f_ctl}, 8'b00111001);
        tick();
        check("R9 nofwd select stays zero", {6'b0, n_sel}, 8'b00);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_dependency();
        t_no_dep();
        t_multicycle();
        t_fetch_miss();
        t_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule